// File: doc/BRIEF.md
# Sized Little-Endian Data Memory Port

This block is a byte-addressed on-chip data memory served through a single load/store port. Each request carries a size code (byte, halfword or word), a base value and an index. The index is multiplied by the access width in bytes and added to the base to form the effective address. Multi-byte values sit in memory with the least significant byte at the lowest address.

Misaligned requests never raise an error. Loads drop the low address bits that the access width does not allow. Misaligned stores write a deterministic, truncated and shifted form of the datum over the whole naturally aligned container. Address bits above the memory size are discarded, so every address wraps into the array. A load returns zero-extended data one cycle after the request. That data stays on the output until the next load.

Top module: `dmem_port`

## Requirements
- R1: Multi-byte values are little-endian. After a 32-bit store of value V at a 4-aligned address A, an 8-bit load at A+k returns byte k of V (bits 8k+7:8k).
- R2: The size code on `size_i` is 0 for 8 bits, 1 for 16 bits, 2 for 32 bits, and 3 acts as 32 bits. The effective address is `base_i + index_i * B`, where B is 1, 2 or 4 bytes for that size.
- R3: A 32-bit load ignores address bits 1:0 and a 16-bit load ignores address bit 0. Loaded data is zero-extended to 32 bits.
- R4: An aligned store changes exactly the bytes the access covers: 1, 2 or 4 bytes starting at the effective address. All other bytes are left as they were.
- R5: A 32-bit store with address bit 0 set writes the full 4-aligned word. The word holds `wdata_i[7:0]` shifted left by 8 × address bits 1:0, and all its other bytes are zero.
- R6: A 32-bit store with address bit 0 clear and bit 1 set writes the full 4-aligned word as `{wdata_i[15:0], 16'h0000}`.
- R7: A 16-bit store with address bit 0 set writes the halfword at the 2-aligned address as `{wdata_i[7:0], 8'h00}`.
- R8: Address bits at and above log2(DEPTH_BYTES) are ignored, so every access wraps within the memory.
- R9: `ready_o` is high in the cycle after each request and low in the cycle after a cycle with no request. Load data appears on `rdata_o` in that same cycle.
- R10: `rdata_o` holds its value through idle cycles and through stores, and changes only after a load.
- R11: While reset is asserted, `ready_o` goes low and `rdata_o` goes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request, one access per cycle it is high |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access width code (see R2) |
| base_i | input | 32 | Base part of the address |
| index_i | input | 32 | Index, scaled by the access width |
| wdata_i | input | 32 | Store data, low bits used for narrow accesses |
| rdata_o | output | 32 | Zero-extended load result |
| ready_o | output | 1 | Response flag for the previous cycle's request |

## Verification
The properties assume that reset is held low for at least one clock edge before traffic starts. They also assume that `req_i`, `we_i` and `size_i` are known at every rising edge, because the zero-extension and hold checks key off these inputs from the previous cycle. The bench drives every input on falling edges only and keeps all fields at defined values, including while the port is idle. It fills the whole memory before issuing its first load, so no load ever returns uninitialised storage.

// File: rtl/dmem_pkg.sv
// Package: shared size encoding and helpers for the sized data memory port.
// Assumes a 32-bit data path made of four byte lanes.
package dmem_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } size_e;

    // log2 of the access width in bytes; code 3 is treated as a word
    function automatic logic [1:0] size_log2(input size_e sz);
        case (sz)
            SZ_BYTE: size_log2 = 2'd0;
            SZ_HALF: size_log2 = 2'd1;
            default: size_log2 = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dmem_addr_gen.sv
// Module: effective address generator.
// Adds the base to the index scaled by the access width in bytes. The sum is
// formed at full width; the caller keeps only the bits the memory decodes.
module dmem_addr_gen
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  size_e              size_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [ADDR_W-1:0]  index_i,
    output logic [ADDR_W-1:0]  ea_o
);

    logic [ADDR_W-1:0] scaled;

    // scale the index by 1, 2 or 4 and add the base
    always_comb begin
        scaled = index_i << size_log2(size_i);
        ea_o   = base_i + scaled;
    end

endmodule

// File: rtl/dmem_store_fmt.sv
// Module: store formatter.
// Turns the size, the low two address bits and the store datum into per-lane
// write enables and word-laid lane data. Misaligned stores keep only the low
// byte or halfword, shifted into place, and write the whole aligned container.
module dmem_store_fmt
    import dmem_pkg::*;
(
    input  size_e               size_i,
    input  logic [1:0]          lo_i,
    input  logic [31:0]         wdata_i,
    output logic [LANES-1:0]    be_o,
    output logic [31:0]         lane_o
);

    logic [15:0] half_val;

    // choose the halfword image for 16-bit stores
    always_comb begin
        half_val = lo_i[0] ? {wdata_i[7:0], 8'h00} : wdata_i[15:0];
    end

    // build byte enables and lane data per access width
    always_comb begin
        be_o   = '0;
        lane_o = '0;
        case (size_i)
            SZ_BYTE: begin
                be_o   = 4'b0001 << lo_i;
                lane_o = {4{wdata_i[7:0]}};
            end
            SZ_HALF: begin
                be_o   = lo_i[1] ? 4'b1100 : 4'b0011;
                lane_o = {half_val, half_val};
            end
            default: begin
                be_o = 4'b1111;
                if (lo_i[0]) begin
                    lane_o = {24'h0, wdata_i[7:0]} << {lo_i, 3'b000};
                end else if (lo_i[1]) begin
                    lane_o = {wdata_i[15:0], 16'h0000};
                end else begin
                    lane_o = wdata_i;
                end
            end
        endcase
    end

endmodule

// File: rtl/dmem_load_fmt.sv
// Module: load formatter.
// Picks the addressed byte or halfword out of a fetched word and zero-extends
// it. The halfword choice uses address bit 1 only; bit 0 is ignored.
module dmem_load_fmt
    import dmem_pkg::*;
(
    input  size_e        size_i,
    input  logic [1:0]   lo_i,
    input  logic [31:0]  word_i,
    output logic [31:0]  rdata_o
);

    // extract and zero-extend the requested part of the word
    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                case (lo_i)
                    2'd0:    rdata_o = {24'h0, word_i[7:0]};
                    2'd1:    rdata_o = {24'h0, word_i[15:8]};
                    2'd2:    rdata_o = {24'h0, word_i[23:16]};
                    default: rdata_o = {24'h0, word_i[31:24]};
                endcase
            end
            SZ_HALF: rdata_o = lo_i[1] ? {16'h0, word_i[31:16]} : {16'h0, word_i[15:0]};
            default: rdata_o = word_i;
        endcase
    end

endmodule

// File: rtl/dmem_lane_ram.sv
// Module: word-organised storage built from independent byte lanes.
// One access per cycle: a write updates the enabled lanes; a read registers
// the whole word, which then holds until the next read. Storage is not reset.
module dmem_lane_ram
    import dmem_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [LANES-1:0]   be_i,
    input  logic [31:0]        lane_i,
    output logic [31:0]        word_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] store_q [WORDS];
        logic [7:0] rd_q;

        // write this lane when enabled
        always_ff @(posedge clk) begin
            if (wr_i && be_i[l]) begin
                store_q[idx_i] <= lane_i[l*8 +: 8];
            end
        end

        // registered read, cleared by reset and held between reads
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else if (rd_i) begin
                rd_q <= store_q[idx_i];
            end
        end

        assign word_o[l*8 +: 8] = rd_q;
    end

endmodule

// File: rtl/dmem_port.sv
// Module: sized little-endian data memory port (top).
// Byte-addressed memory of DEPTH_BYTES (power of two, at least 8) with one
// load/store port. Loads respond one cycle after the request; misaligned
// accesses follow fixed truncation rules and never fault. Upper address bits
// wrap. Reset is synchronous and active low; the storage itself is not reset.
module dmem_port
    import dmem_pkg::*;
#(
    parameter int DEPTH_BYTES = 1024,
    localparam int BYTE_AW = $clog2(DEPTH_BYTES),
    localparam int WORDS   = DEPTH_BYTES / LANES,
    localparam int IDX_W   = BYTE_AW - 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic         we_i,
    input  logic [1:0]   size_i,
    input  logic [31:0]  base_i,
    input  logic [31:0]  index_i,
    input  logic [31:0]  wdata_i,
    output logic [31:0]  rdata_o,
    output logic         ready_o
);

    size_e              size_in;
    logic [31:0]        ea;
    logic [BYTE_AW-1:0] ea_wrap;
    logic [1:0]         lo;
    logic [IDX_W-1:0]   word_idx;
    logic [LANES-1:0]   be;
    logic [31:0]        lane_data;
    logic [31:0]        word_rd;
    logic               rd_en;
    logic               wr_en;
    size_e              size_q;
    logic [1:0]         lo_q;
    logic               ready_q;
    logic               ea_unused;

    assign size_in   = size_e'(size_i);
    assign ea_wrap   = ea[BYTE_AW-1:0];
    assign ea_unused = ^ea[31:BYTE_AW];
    assign lo        = ea_wrap[1:0];
    assign word_idx  = ea_wrap[BYTE_AW-1:2];
    assign rd_en     = req_i && !we_i;
    assign wr_en     = req_i && we_i;

    dmem_addr_gen #(.ADDR_W(32)) u_addr (
        .size_i  (size_in),
        .base_i  (base_i),
        .index_i (index_i),
        .ea_o    (ea)
    );

    dmem_store_fmt u_stfmt (
        .size_i  (size_in),
        .lo_i    (lo),
        .wdata_i (wdata_i),
        .be_o    (be),
        .lane_o  (lane_data)
    );

    dmem_lane_ram #(.WORDS(WORDS)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (rd_en),
        .wr_i   (wr_en),
        .idx_i  (word_idx),
        .be_i   (be),
        .lane_i (lane_data),
        .word_o (word_rd)
    );

    // remember the width and byte offset of the last load for formatting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_WORD;
            lo_q   <= '0;
        end else if (rd_en) begin
            size_q <= size_in;
            lo_q   <= lo;
        end
    end

    // response flag, one cycle after any request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= req_i;
        end
    end

    dmem_load_fmt u_ldfmt (
        .size_i  (size_q),
        .lo_i    (lo_q),
        .word_i  (word_rd),
        .rdata_o (rdata_o)
    );

    assign ready_o = ready_q;

endmodule

// File: rtl/dmem_port_checker.sv
// Module: assertion checker for dmem_port, attached by bind.
// Assumes reset is applied before traffic and control inputs are known.
module dmem_port_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         req_i,
    input logic         we_i,
    input logic [1:0]   size_i,
    input logic [31:0]  rdata_o,
    input logic         ready_o
);

    p_ready_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ready_o);

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !ready_o);

    p_rdata_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(rdata_o));

    p_rdata_hold_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i) |=> $stable(rdata_o));

    p_zext_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'h0));

    p_zext_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && size_i == 2'd1) |=> (rdata_o[31:16] == 16'h0));

endmodule

bind dmem_port dmem_port_checker u_dmem_port_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .we_i    (we_i),
    .size_i  (size_i),
    .rdata_o (rdata_o),
    .ready_o (ready_o)
);

// File: tb/test_dmem_port.sv
// Bench: near-exhaustive sweeps over a 64-byte memory, checked against a
// byte-level reference model computed in the bench.
module test_dmem_port;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [31:0] base_i = '0;
    logic [31:0] index_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        ready_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] model [DEPTH];

    always #5ns clk = ~clk;

    dmem_port #(.DEPTH_BYTES(DEPTH)) i_dmem_port (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .size_i(size_i),
        .base_i(base_i), .index_i(index_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .ready_o(ready_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int width_of(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic int eff(input int sz, input logic [31:0] b, input logic [31:0] x);
        logic [31:0] s;
        s = b + x * width_of(sz);
        return int'(s % DEPTH);
    endfunction

    task automatic m_store(input int sz, input int a, input logic [31:0] v);
        logic [31:0] d;
        int w;
        d = v;
        if (sz >= 2) begin
            if (a % 2 == 1) d = (v & 32'hFF) << ((a % 4) * 8);
            else if ((a / 2) % 2 == 1) d = (v & 32'hFFFF) << 16;
            w = a - (a % 4);
            for (int k = 0; k < 4; k++) model[w + k] = d[k*8 +: 8];
        end else if (sz == 1) begin
            if (a % 2 == 1) d = (v & 32'hFF) << 8;
            w = a - (a % 2);
            model[w] = d[7:0];
            model[w + 1] = d[15:8];
        end else begin
            model[a] = v[7:0];
        end
    endtask

    function automatic logic [31:0] m_load(input int sz, input int a);
        int w;
        if (sz >= 2) begin
            w = a - (a % 4);
            return {model[w + 3], model[w + 2], model[w + 1], model[w]};
        end else if (sz == 1) begin
            w = a - (a % 2);
            return {16'h0, model[w + 1], model[w]};
        end
        return {24'h0, model[a]};
    endfunction

    // one request cycle; afterwards ready/rdata are sampled at a falling edge
    task automatic access(input bit we, input int sz, input logic [31:0] b,
                          input logic [31:0] x, input logic [31:0] wd);
        @(negedge clk);
        req_i = 1'b1; we_i = we; size_i = 2'(sz);
        base_i = b; index_i = x; wdata_i = wd;
        if (we) m_store(sz, eff(sz, b, x), wd);
        @(negedge clk);
        req_i = 1'b0;
        check("R9 ready after request", {31'h0, ready_o}, 32'h1);
    endtask

    task automatic load_chk(input string tag, input int sz, input logic [31:0] b,
                            input logic [31:0] x);
        access(1'b0, sz, b, x, 32'h0);
        check(tag, rdata_o, m_load(sz, eff(sz, b, x)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R11 reset ready", {31'h0, ready_o}, 32'h0);
        check("R11 reset rdata", rdata_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // fill with byte stores (R2 index scale 1, upper data bits junk)
        for (int a = 0; a < DEPTH; a++)
            access(1'b1, 0, 32'h0, 32'(a), 32'hDEAD_BE00 | 32'((a * 37 + 5) % 256));

        // every size at every address (R1 byte order, R3 truncation + zero-extend)
        for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < DEPTH; a++)
                load_chk((sz == 0) ? "R1 byte load" : "R3 sized load", sz, 32'(a), 32'h0);

        // little-endian word store then byte reads (R1)
        access(1'b1, 2, 32'd40, 32'd0, 32'h8877_6655);
        for (int k = 0; k < 4; k++) load_chk("R1 byte lane", 0, 32'd40, 32'(k));

        // index scaling and size code 3 (R2)
        for (int sz = 0; sz < 4; sz++)
            for (int x = 0; x < 8; x++)
                load_chk("R2 scaled index", sz, 32'd3, 32'(x));

        // stores of each size at each offset, then compare the region
        for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off++) begin
                for (int w = 0; w < 4; w++)
                    access(1'b1, 2, 32'd16, 32'(w), 32'h5A3C_9612 ^ 32'(w * 32'h0101_0101));
                access(1'b1, sz, 32'(20 + off), 32'h0, 32'hA1B2_C3D4 ^ 32'(off));
                for (int w = 0; w < 4; w++)
                    load_chk((sz == 2 && off % 2 == 1) ? "R5 word store odd" :
                             (sz == 2 && off == 2)     ? "R6 word store half" :
                             (sz == 1 && off % 2 == 1) ? "R7 half store odd" :
                                                         "R4 aligned store",
                             2, 32'd16, 32'(w));
            end

        // wrap-around (R8)
        access(1'b1, 2, 32'(DEPTH * 5 + 8), 32'h0, 32'hCAFE_F00D);
        load_chk("R8 wrap high base", 2, 32'd8, 32'h0);
        load_chk("R8 wrap negative", 1, 32'hFFFF_FFFC, 32'd3);

        // hold behaviour (R10) and idle ready (R9)
        load_chk("R10 setup load", 2, 32'd8, 32'h0);
        held = rdata_o;
        repeat (3) @(negedge clk);
        check("R9 ready low when idle", {31'h0, ready_o}, 32'h0);
        check("R10 held through idle", rdata_o, held);
        access(1'b1, 2, 32'd8, 32'h0, 32'h1234_5678);
        check("R10 held through store", rdata_o, held);
        load_chk("R10 new load replaces", 2, 32'd8, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule